// File: doc/BRIEF.md
# Multi-Rail Supervisor Core

This block is the clocked core of a processor supervisor. Three comparator flags come in, one for each monitored supply rail, and each flag is high while its rail is above its trip point. From these flags, an active-low push-button input and the two wires of a two-wire serial bus, the block produces an active-low system reset, separate fail indications for the second and third rails, and an active-low watchdog output.

After power-up, a primary-rail dip or a manual reset press, the system reset is held for a selectable hold-off interval. This keeps the processor stopped until the supply and the clocks have settled. The second-rail flag can also be folded into the reset. The watchdog does not need a dedicated kick pin. It is restarted by snooping ordinary bus traffic: a start condition, a falling SCL edge, and then a stop condition. If that pattern does not appear within the selected timeout, the watchdog output goes low.

The six asynchronous inputs pass through two-flop synchronizers. The configuration inputs (`hold_sel`, `wd_sel`, `v2_to_reset`) are assumed to be quasi-static straps.

Top module: `supervisor_core`

## Requirements
- R1: While `rst_n` is low, and from the moment it goes high, `sys_rst_n` is low and `wdo_n` is high.
- R2: `sys_rst_n` goes high only after every reset cause has been clear for the hold-off count. The count is HOLD_BASE×1, ×4, ×16 or ×64 cycles for `hold_sel` codes 0, 1, 2 and 3, plus up to three cycles of synchronizer latency.
- R3: When `rail1_ok` falls, `sys_rst_n` goes low within three cycles. It stays low until the rail has been back up for a full hold-off count.
- R4: While `mr_n` is low, `sys_rst_n` stays low. After `mr_n` is released, `sys_rst_n` stays low for a further hold-off count.
- R5: `v3_fail_n` follows `rail3_ok` after the two-cycle synchronizer and nothing else, with no hold-off. The third rail never affects `sys_rst_n`.
- R6: `v2_fail_n` is low while `rail2_ok` is low. When `v2_to_reset` is 1, a low second rail is also a reset cause. When `v2_to_reset` is 0, the second rail has no effect on `sys_rst_n`.
- R7: A valid restart zeroes the watchdog count and drives `wdo_n` high. A valid restart is SDA falling while SCL is high (start), then SCL falling, then SDA rising while SCL is high (stop).
- R8: Two patterns give no restart. The first is a start followed by a stop with no SCL fall in between. The second is an armed pattern that sees a new start before its stop, followed by a stop with no SCL fall after that start.
- R9: For `wd_sel` codes 1, 2 and 3, `wdo_n` goes low after WD_BASE×1, ×4 or ×16 cycles without a restart. It stays low until a restart or a system reset.
- R10: With `wd_sel` = 0 the watchdog is disabled, and `wdo_n` stays high however long the bus is idle.
- R11: While `sys_rst_n` is low, the watchdog count is held at zero and `wdo_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rail1_ok | input | 1 | Primary rail above trip point (async) |
| rail2_ok | input | 1 | Second rail above trip point (async) |
| rail3_ok | input | 1 | Third rail above trip point (async) |
| mr_n | input | 1 | Manual reset push-button, active low (async) |
| scl | input | 1 | Serial bus clock, snooped (async) |
| sda | input | 1 | Serial bus data, snooped (async) |
| hold_sel | input | 2 | Hold-off length code |
| wd_sel | input | 2 | Watchdog timeout code, 0 = disabled |
| v2_to_reset | input | 1 | Make a low second rail a reset cause |
| sys_rst_n | output | 1 | System reset, active low |
| v2_fail_n | output | 1 | Second rail fail, active low |
| v3_fail_n | output | 1 | Third rail fail, active low |
| wdo_n | output | 1 | Watchdog expired, active low |

## Verification
The hold-off is exercised with three different codes and with three reset causes: the primary rail, the push-button and the second rail with the OR enabled. Each release is bracketed by one sample just before the expected count and one just after it, which separates a wrong code decode from an early or late release. The watchdog is driven with a full start/SCL-fall/stop pattern, with a start followed at once by a stop, and with an armed pattern interrupted by a second start. The last two must leave the timeout running, which shows that the restart logic really demands the SCL fall and the stop. The timeout is also run with the watchdog disabled, with two different timeout codes, and across a manual reset, which shows that the count is held while the system is in reset.

// File: rtl/sup_pkg.sv
// Package: shared types and constants for the supervisor core.
// Assumes nothing beyond IEEE 1800-2017.
package sup_pkg;

    // Bus snoop progress toward a watchdog restart.
    typedef enum logic [1:0] {
        SN_IDLE    = 2'd0,  // no start seen
        SN_STARTED = 2'd1,  // start seen, waiting for SCL to fall
        SN_ARMED   = 2'd2   // SCL fell after start, waiting for stop
    } snoop_st_e;

    // Watchdog select code meaning "disabled".
    localparam logic [1:0] WD_SEL_OFF = 2'b00;

endpackage

// File: rtl/sup_sync.sv
// Module: sup_sync
// Two-flop synchronizer for W independent asynchronous bits.
// Assumes: each bit is a level that is stable for several clocks; the
// reset value of each bit is chosen so that it reads as "safe".
module sup_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta_q;
            logic sync_q;

            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[i];
                    sync_q <= RST_VAL[i];
                end else begin
                    meta_q <= d[i];
                    sync_q <= meta_q;
                end
            end

            assign q[i] = sync_q;
        end
    endgenerate

endmodule

// File: rtl/sup_holdoff.sv
// Module: sup_holdoff
// Reset hold-off timer. While any fault is present, the reset is asserted
// and the count is zero. Once the fault clears, the reset is released after
// HOLD_BASE << (2*hold_sel) consecutive fault-free cycles.
// Assumes: fault is already synchronous; hold_sel is quasi-static.
module sup_holdoff #(
    parameter int HOLD_BASE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault,
    input  logic [1:0] hold_sel,
    output logic       rst_active
);

    localparam int CW = $clog2(HOLD_BASE * 64) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    // Hold-off length: the base scaled by 1, 4, 16 or 64.
    always_comb target = CW'(HOLD_BASE) << {hold_sel, 1'b0};

    // Count fault-free cycles and release the reset at the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            rst_active <= 1'b1;
        end else if (fault) begin
            cnt        <= '0;
            rst_active <= 1'b1;
        end else if (rst_active) begin
            if (cnt >= target - 1'b1) begin
                rst_active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: any fault forces the reset active on the next cycle.
    a_r3_fault_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> rst_active);

    // R2: no release while the count is short of the target.
    a_r2_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_active && !fault && (cnt + 1'b1 < target)) |=> rst_active);

    // R2: a released reset stays released while no fault is present.
    a_r2_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_active && !fault) |=> !rst_active);

endmodule

// File: rtl/sup_bus_snoop.sv
// Module: sup_bus_snoop
// Watches synchronized SCL/SDA levels for a start condition, a following
// SCL fall, and then a stop condition. It emits a one-cycle kick when the
// whole pattern completes. A new start before the stop discards the armed
// pattern.
// Assumes: scl and sda are already synchronized and each level is held for
// at least one clock.
module sup_bus_snoop
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic kick
);

    logic      scl_p;
    logic      sda_p;
    logic      start_det;
    logic      stop_det;
    logic      scl_fall;
    snoop_st_e state;

    // Keep the previous bus levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
        end
    end

    // Decode start, stop and the SCL falling edge.
    always_comb begin
        start_det = scl && scl_p && sda_p && !sda;
        stop_det  = scl && scl_p && !sda_p && sda;
        scl_fall  = scl_p && !scl;
    end

    // Track progress through start, SCL fall and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SN_IDLE;
            kick  <= 1'b0;
        end else begin
            kick <= 1'b0;
            if (start_det) begin
                state <= SN_STARTED;
            end else if (stop_det) begin
                kick  <= (state == SN_ARMED);
                state <= SN_IDLE;
            end else if (scl_fall && state == SN_STARTED) begin
                state <= SN_ARMED;
            end
        end
    end

    // R8: start and stop can never decode in the same cycle.
    a_r8_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det}));

    // R7: a kick always leaves the tracker idle.
    a_r7_kick_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> state == SN_IDLE);

    // R8: no kick unless the tracker was armed one cycle earlier.
    a_r8_kick_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SN_ARMED) |=> !kick);

endmodule

// File: rtl/sup_watchdog.sv
// Module: sup_watchdog
// Watchdog timer. It counts cycles since the last kick and raises
// wdo_active once the count reaches WD_BASE << (2*(wd_sel-1)). The output
// is sticky until the next kick. The counter is held clear while hold_clr
// is high or while the watchdog is disabled.
// Assumes: kick is a single-cycle synchronous pulse.
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int WD_BASE = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_clr,
    input  logic [1:0] wd_sel,
    input  logic       kick,
    output logic       wdo_active
);

    localparam int WW = $clog2(WD_BASE * 16) + 1;

    logic [WW-1:0] cnt;
    logic [WW-1:0] limit;
    logic [1:0]    sel_m1;

    // Timeout length: the base scaled by 1, 4 or 16.
    always_comb begin
        sel_m1 = wd_sel - 2'd1;
        limit  = WW'(WD_BASE) << {sel_m1, 1'b0};
    end

    // Count idle cycles and flag expiry; kicks and resets clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr || wd_sel == WD_SEL_OFF) begin
            cnt        <= '0;
            wdo_active <= 1'b0;
        end else if (kick) begin
            cnt        <= '0;
            wdo_active <= 1'b0;
        end else if (cnt >= limit - 1'b1) begin
            wdo_active <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R11: while the system is in reset, the counter and output are clear.
    a_r11_clear_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (!wdo_active && cnt == '0));

    // R10: a disabled watchdog never expires.
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == WD_SEL_OFF) |=> !wdo_active);

    // R7: a kick clears the expiry flag.
    a_r7_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !wdo_active);

    // R9: once expired, the flag holds until a kick, a reset or disable.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wdo_active && !kick && !hold_clr && wd_sel != WD_SEL_OFF) |=> wdo_active);

endmodule

// File: rtl/supervisor_core.sv
// Module: supervisor_core
// Digital core of a three-rail processor supervisor. It synchronizes the
// rail flags, manual reset and snooped bus wires, combines the reset
// causes, times the reset hold-off and runs the bus-restarted watchdog.
// Assumes: hold_sel, wd_sel and v2_to_reset are static straps; the rail
// flags are high while the rail is above its trip point.
module supervisor_core #(
    parameter int HOLD_BASE = 16,
    parameter int WD_BASE   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rail1_ok,
    input  logic       rail2_ok,
    input  logic       rail3_ok,
    input  logic       mr_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [1:0] hold_sel,
    input  logic [1:0] wd_sel,
    input  logic       v2_to_reset,
    output logic       sys_rst_n,
    output logic       v2_fail_n,
    output logic       v3_fail_n,
    output logic       wdo_n
);

    localparam int NSYNC = 6;
    // Reset values: rails read as failed, button released, bus idle high.
    localparam logic [NSYNC-1:0] SYNC_RST = 6'b000_111;

    logic [NSYNC-1:0] async_in;
    logic [NSYNC-1:0] sync_in;
    logic r1_s, r2_s, r3_s, mr_s, scl_s, sda_s;
    logic fault;
    logic rst_active;
    logic kick;
    logic wdo_active;

    // Bundle the asynchronous inputs for synchronization.
    always_comb async_in = {rail1_ok, rail2_ok, rail3_ok, mr_n, scl, sda};

    sup_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_in)
    );

    // Split the synchronized bundle and combine the reset causes.
    always_comb begin
        {r1_s, r2_s, r3_s, mr_s, scl_s, sda_s} = sync_in;
        fault = !r1_s || !mr_s || (v2_to_reset && !r2_s);
    end

    sup_holdoff #(.HOLD_BASE(HOLD_BASE)) u_holdoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (fault),
        .hold_sel   (hold_sel),
        .rst_active (rst_active)
    );

    sup_bus_snoop u_snoop (
        .clk   (clk),
        .rst_n (rst_n),
        .scl   (scl_s),
        .sda   (sda_s),
        .kick  (kick)
    );

    sup_watchdog #(.WD_BASE(WD_BASE)) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clr   (rst_active),
        .wd_sel     (wd_sel),
        .kick       (kick),
        .wdo_active (wdo_active)
    );

    // Drive the active-low outputs.
    always_comb begin
        sys_rst_n = !rst_active;
        v2_fail_n = r2_s;
        v3_fail_n = r3_s;
        wdo_n     = !wdo_active;
    end

    // R11: the watchdog output is inactive one cycle into any system reset.
    a_r11_wdo_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> wdo_n);

    // R4: a held push-button keeps the system in reset.
    a_r4_button_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_s |=> !sys_rst_n);

endmodule

// File: tb/supervisor_core_test.sv
// Directed bench for supervisor_core: one task per scenario.
module supervisor_core_test;

    localparam int HB = 16;
    localparam int WB = 256;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rail1_ok, rail2_ok, rail3_ok, mr_n, scl, sda;
    logic [1:0] hold_sel, wd_sel;
    logic       v2_to_reset;
    logic       sys_rst_n, v2_fail_n, v3_fail_n, wdo_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    supervisor_core #(.HOLD_BASE(HB), .WD_BASE(WB)) uut (
        .clk(clk), .rst_n(rst_n), .rail1_ok(rail1_ok), .rail2_ok(rail2_ok),
        .rail3_ok(rail3_ok), .mr_n(mr_n), .scl(scl), .sda(sda),
        .hold_sel(hold_sel), .wd_sel(wd_sel), .v2_to_reset(v2_to_reset),
        .sys_rst_n(sys_rst_n), .v2_fail_n(v2_fail_n), .v3_fail_n(v3_fail_n),
        .wdo_n(wdo_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pin(input logic v, input logic e, input string req);
        check(v === e, req, int'(v), int'(e));
    endtask

    // Reset must still be held shortly before the count and be free just after.
    task automatic expect_release(input int t, input string req);
        wait_cyc(t - 2);
        expect_pin(sys_rst_n, 1'b0, req);
        wait_cyc(6);
        expect_pin(sys_rst_n, 1'b1, req);
    endtask

    task automatic set_bus(input logic c, input logic d);
        scl = c;
        sda = d;
        wait_cyc(4);
    endtask

    // Valid restart: start, SCL fall, SCL rise, stop.
    task automatic bus_kick();
        set_bus(1'b1, 1'b0);
        set_bus(1'b0, 1'b0);
        set_bus(1'b1, 1'b0);
        set_bus(1'b1, 1'b1);
    endtask

    // R1, R2: power-up behaviour with the shortest hold-off.
    task automatic t_power_up();
        rst_n = 1'b0;
        rail1_ok = 1'b0; rail2_ok = 1'b1; rail3_ok = 1'b1; mr_n = 1'b1;
        scl = 1'b1; sda = 1'b1; hold_sel = 2'd0; wd_sel = 2'd0; v2_to_reset = 1'b0;
        wait_cyc(5);
        expect_pin(sys_rst_n, 1'b0, "R1 reset held during rst_n");
        expect_pin(wdo_n, 1'b1, "R1 wdo idle during rst_n");
        rst_n = 1'b1;
        rail1_ok = 1'b1;
        expect_release(HB, "R2 power-up release sel0");
    endtask

    // R2, R3: longer hold-off codes after a primary rail dip.
    task automatic t_hold_sel(input logic [1:0] sel);
        hold_sel = sel;
        rail1_ok = 1'b0;
        wait_cyc(5);
        expect_pin(sys_rst_n, 1'b0, "R3 dip asserts reset");
        rail1_ok = 1'b1;
        expect_release(HB << (2 * sel), "R2 release with hold_sel code");
        hold_sel = 2'd0;
    endtask

    // R3: a sustained brownout keeps reset low.
    task automatic t_brownout();
        rail1_ok = 1'b0;
        wait_cyc(4);
        expect_pin(sys_rst_n, 1'b0, "R3 brownout asserts within 3 cycles");
        wait_cyc(60);
        expect_pin(sys_rst_n, 1'b0, "R3 brownout still held");
        rail1_ok = 1'b1;
        expect_release(HB, "R3 release after recovery");
    endtask

    // R4: manual reset hold and release.
    task automatic t_manual();
        mr_n = 1'b0;
        wait_cyc(4);
        expect_pin(sys_rst_n, 1'b0, "R4 button asserts reset");
        wait_cyc(100);
        expect_pin(sys_rst_n, 1'b0, "R4 button held");
        mr_n = 1'b1;
        expect_release(HB, "R4 hold-off after release");
    endtask

    // R5: third rail flag follows immediately and never touches reset.
    task automatic t_v3();
        rail3_ok = 1'b0;
        wait_cyc(3);
        expect_pin(v3_fail_n, 1'b0, "R5 v3 fail low");
        wait_cyc(40);
        expect_pin(sys_rst_n, 1'b1, "R5 v3 no reset effect");
        rail3_ok = 1'b1;
        wait_cyc(3);
        expect_pin(v3_fail_n, 1'b1, "R5 v3 fail high again");
    endtask

    // R6: second rail flag, with and without the reset OR.
    task automatic t_v2();
        v2_to_reset = 1'b0;
        rail2_ok = 1'b0;
        wait_cyc(3);
        expect_pin(v2_fail_n, 1'b0, "R6 v2 fail low");
        wait_cyc(40);
        expect_pin(sys_rst_n, 1'b1, "R6 v2 ignored when OR off");
        rail2_ok = 1'b1;
        wait_cyc(3);
        expect_pin(v2_fail_n, 1'b1, "R6 v2 fail high again");
        v2_to_reset = 1'b1;
        rail2_ok = 1'b0;
        wait_cyc(4);
        expect_pin(sys_rst_n, 1'b0, "R6 v2 ORed into reset");
        rail2_ok = 1'b1;
        expect_release(HB, "R6 release after v2 recovery");
        v2_to_reset = 1'b0;
    endtask

    // R10: disabled watchdog never fires.
    task automatic t_wd_off();
        wd_sel = 2'd0;
        wait_cyc(WB * 20);
        expect_pin(wdo_n, 1'b1, "R10 disabled watchdog quiet");
    endtask

    // R9, R7: timeout, restart and a second timeout code.
    task automatic t_wd_timeout();
        wd_sel = 2'd1;
        wait_cyc(WB - 6);
        expect_pin(wdo_n, 1'b1, "R9 no early expiry");
        wait_cyc(12);
        expect_pin(wdo_n, 1'b0, "R9 expiry after timeout");
        bus_kick();
        wait_cyc(4);
        expect_pin(wdo_n, 1'b1, "R7 restart clears wdo");
        wait_cyc(WB - 24);
        expect_pin(wdo_n, 1'b1, "R7 count restarted");
        wait_cyc(32);
        expect_pin(wdo_n, 1'b0, "R9 expiry after restart");
        wd_sel = 2'd2;
        bus_kick();
        wait_cyc(4);
        wait_cyc(4 * WB - 24);
        expect_pin(wdo_n, 1'b1, "R9 code 2 no early expiry");
        wait_cyc(32);
        expect_pin(wdo_n, 1'b0, "R9 code 2 expiry");
    endtask

    // R8: incomplete patterns must not restart the watchdog.
    task automatic t_wd_discard();
        wd_sel = 2'd1;
        bus_kick();
        wait_cyc(4);
        expect_pin(wdo_n, 1'b1, "R8 clean start");
        set_bus(1'b1, 1'b0);   // start
        set_bus(1'b1, 1'b1);   // stop with no SCL fall
        set_bus(1'b1, 1'b0);   // start
        set_bus(1'b0, 1'b0);   // SCL fall: armed
        set_bus(1'b0, 1'b1);
        set_bus(1'b1, 1'b1);
        set_bus(1'b1, 1'b0);   // new start discards the arm
        set_bus(1'b1, 1'b1);   // stop without a fresh SCL fall
        expect_pin(wdo_n, 1'b1, "R8 no spurious expiry");
        wait_cyc(WB - 16);
        expect_pin(wdo_n, 1'b0, "R8 discarded patterns left timer running");
    endtask

    // R11: watchdog held clear through a manual reset.
    task automatic t_wd_in_reset();
        wd_sel = 2'd1;
        mr_n = 1'b0;
        wait_cyc(6);
        expect_pin(wdo_n, 1'b1, "R11 wdo cleared by reset");
        wait_cyc(2 * WB);
        expect_pin(wdo_n, 1'b1, "R11 count held in reset");
        mr_n = 1'b1;
        expect_release(HB, "R11 release before timing");
        wait_cyc(WB - 30);
        expect_pin(wdo_n, 1'b1, "R11 count started from zero");
        wait_cyc(40);
        expect_pin(wdo_n, 1'b0, "R11 expiry after release");
        wd_sel = 2'd0;
    endtask

    initial begin
        t_power_up();
        t_hold_sel(2'd2);
        t_hold_sel(2'd3);
        t_brownout();
        t_manual();
        t_v3();
        t_v2();
        t_wd_off();
        t_wd_timeout();
        t_wd_discard();
        t_wd_in_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule